// File: doc/BRIEF.md
# Stereo Volume Control Serial Port

This block takes mute and attenuation settings for a stereo output over a three-wire serial link: a shift clock, a data line and a latch strobe. All three run asynchronously to the audio clock. Control bytes are shifted in MSB first. The rising edge of the latch strobe captures the most recent byte. Bit 7 of that byte picks the left or right channel, bit 6 is that channel's mute and bits 5:0 are an unsigned attenuation code in 1 dB steps.

A latched byte does not change the outputs straight away. It crosses into the audio clock domain through a toggle flag and a two-flop synchronizer, waits there as a pending command, and is applied on the next edge of the frame clock (LRCLK), either rising or falling. An external mute input forces both channel mute outputs high whatever the registers hold. Scaling the audio samples is left to the datapath that consumes these outputs.

Top module: `vol_ctrl_port`

## Requirements
- R1: Bits are sampled on the rising edge of `ser_clk_i`, MSB first, and only the last 8 bits shifted before the rising edge of `ser_latch_i` form the command; any earlier bits are dropped.
- R2: Command bit 7 selects the channel (1 = right, 0 = left). A command never changes the other channel's settings.
- R3: Command bit 6 is the selected channel's mute (1 = muted, 0 = normal) and appears on `mute_l_o` or `mute_r_o`.
- R4: Command bits 5:0 appear unchanged on `atten_l_o` or `atten_r_o` as the attenuation code (0 = 0 dB, 63 = −63 dB).
- R5: After reset both channels read mute 0 and attenuation 0.
- R6: A latched command does not change any output before the next `lrclk_i` edge (rising or falling). If the latch edge comes at least 4 `clk_i` cycles before that edge, the new value shows within 4 `clk_i` cycles after it. Successive latch edges are at least 4 `clk_i` cycles apart.
- R7: When the latch edge and an `lrclk_i` edge happen together, the outputs after that edge hold either the old or the new setting, never a mix. The new setting is in force after the following `lrclk_i` edge.
- R8: If several commands are latched between two `lrclk_i` edges, only the last one is applied.
- R9: While `ext_mute_i` is high, `mute_l_o` and `mute_r_o` are both high. When it drops, each mute output returns to its register value.
- R10: An `lrclk_i` edge with no command pending leaves all settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Audio-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| lrclk_i | input | 1 | Frame clock; both edges apply pending commands |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_latch_i | input | 1 | Latch strobe; rising edge captures the byte |
| ext_mute_i | input | 1 | Mutes both channels |
| mute_l_o | output | 1 | Left mute, including the external mute |
| mute_r_o | output | 1 | Right mute, including the external mute |
| atten_l_o | output | 6 | Left attenuation code |
| atten_r_o | output | 6 | Right attenuation code |

## Verification
On every audio clock cycle, the assertions check that channel settings change only when a frame-clock edge meets a pending command, that a command leaves the unselected channel untouched, and that a pending command clears once it has been applied. Other behaviours can only be shown by the bench's scenarios: the serial bit order, dropping of surplus bits, last-write-wins, the external mute override, and that a coincident latch and frame edge yields the old or new value and then settles on the new one. The bench checks these against a behavioural model on every cycle outside the short settling window after each frame edge.

// File: rtl/vol_ctrl_pkg.sv
package vol_ctrl_pkg;
  localparam int unsigned CMD_W    = 8;
  localparam int unsigned ATT_W    = 6;
  localparam int unsigned SEL_BIT  = 7;
  localparam int unsigned MUTE_BIT = 6;

  typedef struct packed {
    logic             mute;
    logic [ATT_W-1:0] att;
  } chan_cfg_t;

  function automatic chan_cfg_t decode_cmd(input logic [CMD_W-1:0] cmd);
    chan_cfg_t c;
    c.mute = cmd[MUTE_BIT];
    c.att  = cmd[ATT_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/vol_ctrl_serial.sv
module vol_ctrl_serial
  import vol_ctrl_pkg::*;
(
  input  logic             ser_clk_i,
  input  logic             ser_latch_i,
  input  logic             rst_ni,
  input  logic             ser_data_i,
  output logic [CMD_W-1:0] held_o,
  output logic             tgl_o
);
  logic [CMD_W-1:0] shreg;

  // older bits fall off the top
  always_ff @(posedge ser_clk_i or negedge rst_ni) begin
    if (!rst_ni) shreg <= '0;
    else         shreg <= {shreg[CMD_W-2:0], ser_data_i};
  end

  // held byte stays put until the next latch
  always_ff @(posedge ser_latch_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o <= '0;
      tgl_o  <= 1'b0;
    end else begin
      held_o <= shreg;
      tgl_o  <= ~tgl_o;
    end
  end
endmodule

// File: rtl/vol_ctrl_sync.sv
module vol_ctrl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff <= '0;
    else         ff <= {ff[STAGES-2:0], d_i};
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/vol_ctrl_apply.sv
module vol_ctrl_apply
  import vol_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tgl_s_i,
  input  logic             lr_s_i,
  input  logic [CMD_W-1:0] cmd_i,
  output chan_cfg_t        cfg_l_o,
  output chan_cfg_t        cfg_r_o
);
  logic             tgl_q, lr_q;
  logic [CMD_W-1:0] pend;
  logic             pend_v;
  logic             new_req, lr_edge;

  assign new_req = tgl_s_i ^ tgl_q;
  assign lr_edge = lr_s_i ^ lr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q   <= 1'b0;
      lr_q    <= 1'b0;
      pend    <= '0;
      pend_v  <= 1'b0;
      cfg_l_o <= '0;
      cfg_r_o <= '0;
    end else begin
      tgl_q <= tgl_s_i;
      lr_q  <= lr_s_i;
      if (lr_edge && pend_v) begin
        if (pend[SEL_BIT]) cfg_r_o <= decode_cmd(pend);
        else               cfg_l_o <= decode_cmd(pend);
      end
      // cmd_i has been stable since the toggle left the serial side
      if (new_req) begin
        pend   <= cmd_i;
        pend_v <= 1'b1;
      end else if (lr_edge) begin
        pend_v <= 1'b0;
      end
    end
  end

  // R6
  hold_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lr_edge && pend_v) |=> $stable({cfg_l_o, cfg_r_o}));

  // R2
  left_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v && pend[SEL_BIT]) |=> $stable(cfg_l_o));

  // R2
  right_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_v && !pend[SEL_BIT]) |=> $stable(cfg_r_o));

  // R8
  pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lr_edge && pend_v && !new_req) |=> !pend_v);
endmodule

// File: rtl/vol_ctrl_port.sv
module vol_ctrl_port
  import vol_ctrl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lrclk_i,
  input  logic             ser_clk_i,
  input  logic             ser_data_i,
  input  logic             ser_latch_i,
  input  logic             ext_mute_i,
  output logic             mute_l_o,
  output logic             mute_r_o,
  output logic [ATT_W-1:0] atten_l_o,
  output logic [ATT_W-1:0] atten_r_o
);
  logic [CMD_W-1:0] held;
  logic             tgl, tgl_s, lr_s;
  chan_cfg_t        cfg_l, cfg_r;

  vol_ctrl_serial u_serial (
    .ser_clk_i   (ser_clk_i),
    .ser_latch_i (ser_latch_i),
    .rst_ni      (rst_ni),
    .ser_data_i  (ser_data_i),
    .held_o      (held),
    .tgl_o       (tgl)
  );

  vol_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_tgl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (tgl),
    .q_o    (tgl_s)
  );

  vol_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync_lr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lrclk_i),
    .q_o    (lr_s)
  );

  vol_ctrl_apply u_apply (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tgl_s_i (tgl_s),
    .lr_s_i  (lr_s),
    .cmd_i   (held),
    .cfg_l_o (cfg_l),
    .cfg_r_o (cfg_r)
  );

  assign mute_l_o  = cfg_l.mute | ext_mute_i;
  assign mute_r_o  = cfg_r.mute | ext_mute_i;
  assign atten_l_o = cfg_l.att;
  assign atten_r_o = cfg_r.att;
endmodule

// File: tb/vol_ctrl_port_bench.sv
module vol_ctrl_port_bench;
  logic clk = 1'b0, rst_ni = 1'b0, lrclk = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_latch = 1'b0, ext_mute = 1'b0;
  logic mute_l, mute_r;
  logic [5:0] atten_l, atten_r;

  int checks = 0, errors = 0;
  int blank = 0;
  bit hold = 1'b1;
  bit done = 1'b0;

  // reference state
  bit       m_ml = 0, m_mr = 0;
  int       m_al = 0, m_ar = 0;
  bit [7:0] pend = 0;
  bit       pv = 0;

  always #10 clk = ~clk;

  vol_ctrl_port u_vol_ctrl_port (
    .clk_i(clk), .rst_ni(rst_ni), .lrclk_i(lrclk),
    .ser_clk_i(ser_clk), .ser_data_i(ser_data), .ser_latch_i(ser_latch),
    .ext_mute_i(ext_mute), .mute_l_o(mute_l), .mute_r_o(mute_r),
    .atten_l_o(atten_l), .atten_r_o(atten_r)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison with the model (R6, R9)
  always @(negedge clk) begin
    if (blank > 0) blank--;
    else if (!hold && !done) begin
      chk("R6/R9 mute_l", mute_l, m_ml | ext_mute);
      chk("R6/R9 mute_r", mute_r, m_mr | ext_mute);
      chk("R6 atten_l", atten_l, m_al);
      chk("R6 atten_r", atten_r, m_ar);
    end
  end

  task automatic shift_bits(input bit [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      #15 ser_clk = 1'b1;
      #35 ser_clk = 1'b0;
      #20;
    end
  endtask

  task automatic latch_cmd(input bit [7:0] b);
    ser_latch = 1'b1;
    pend = b; pv = 1'b1;
    #40 ser_latch = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  task automatic send(input bit [7:0] b);
    shift_bits({8'h00, b}, 8);
    latch_cmd(b);
  endtask

  task automatic apply_model();
    if (pv) begin
      if (pend[7]) begin m_mr = pend[6]; m_ar = int'(pend[5:0]); end
      else         begin m_ml = pend[6]; m_al = int'(pend[5:0]); end
    end
    pv = 1'b0;
  endtask

  task automatic lr_toggle();
    @(posedge clk); #3;
    blank = 5;
    lrclk = ~lrclk;
    apply_model();
    hold = 1'b0;
    repeat (8) @(posedge clk);
  endtask

  task automatic sample_at_negedge();
    @(negedge clk); #1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #3 rst_ni = 1'b1;
    sample_at_negedge();
    // R5 reset state
    chk("R5 mute_l", mute_l, 0); chk("R5 mute_r", mute_r, 0);
    chk("R5 atten_l", atten_l, 0); chk("R5 atten_r", atten_r, 0);
    hold = 1'b0;

    // R4 left attenuation code
    send(8'h05);
    sample_at_negedge();
    chk("R6 not before edge", atten_l, 0);
    lr_toggle();
    sample_at_negedge();
    chk("R4 atten_l", atten_l, 5);
    chk("R2 right untouched", atten_r, 0);

    // R3 right mute + atten
    send(8'hC3);
    lr_toggle();
    sample_at_negedge();
    chk("R3 mute_r", mute_r, 1);
    chk("R4 atten_r", atten_r, 3);
    chk("R2 left untouched", atten_l, 5);

    // R1 surplus leading bits dropped; code 63
    shift_bits(16'h0F3F, 12);
    latch_cmd(8'h3F);
    lr_toggle();
    sample_at_negedge();
    chk("R1 atten_l", atten_l, 63);
    chk("R1 mute_l", mute_l, 0);

    // R10 edge with nothing pending (falling edge of lrclk here)
    lr_toggle();
    sample_at_negedge();
    chk("R10 atten_l", atten_l, 63);
    chk("R10 atten_r", atten_r, 3);

    // R8 last write wins
    send(8'h41);
    send(8'h2A);
    lr_toggle();
    sample_at_negedge();
    chk("R8 atten_l", atten_l, 42);
    chk("R8 mute_l", mute_l, 0);

    // R9 external mute
    @(posedge clk); #3 ext_mute = 1'b1;
    sample_at_negedge();
    chk("R9 mute_l", mute_l, 1); chk("R9 mute_r", mute_r, 1);
    #3 ext_mute = 1'b0;
    sample_at_negedge();
    chk("R9 release l", mute_l, 0); chk("R9 release r", mute_r, 1);

    // R7 latch and frame edge together
    shift_bits(16'h0011, 8);
    @(posedge clk); #3;
    hold = 1'b1;
    ser_latch = 1'b1;
    lrclk = ~lrclk;
    pend = 8'h11; pv = 1'b1;
    #40 ser_latch = 1'b0;
    repeat (8) @(posedge clk);
    sample_at_negedge();
    chk("R7 old or new", int'(atten_l == 6'd42 || atten_l == 6'd17), 1);
    chk("R7 mute_l", mute_l, 0);
    chk("R7 right untouched", atten_r, 3);
    lr_toggle();
    sample_at_negedge();
    chk("R7 settled", atten_l, 17);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule